// File: doc/BRIEF.md
# Wide Smoothing Edge Filter

This block smooths the pixels on both sides of a block edge in a region judged flat. It takes one column of sixteen pixels that straddle the edge. Eight of them lie on the near side, from p7 (farthest) to p0 (next to the edge). The other eight lie on the far side, from q0 (next to the edge) to q7. The block returns the same column with an inner band of pixels replaced by low-pass values. In the short mode it reads p3..q3 and rewrites the six pixels p2..q2. In the long mode it reads all sixteen pixels and rewrites the fourteen pixels p6..q6.

Each new pixel is a weighted window sum with rounding, shifted right by 3 in the short mode or by 4 in the long mode. The block does not evaluate each window from scratch. It keeps one accumulator and moves it one position per cycle: it removes two old taps and adds two new ones. Every tap comes from the unfiltered copy of the column. Where the window runs past the outermost pixel, that pixel is repeated. A select bit that arrives with the column decides whether the smoothed values are used. When it is clear, the column comes back unchanged. The decision logic that produces the select bit and the narrow filter belong to other blocks.

A column is accepted on a clock edge when `in_valid` and `in_ready` are both high. The result appears as a one-cycle `out_valid` pulse once all outputs have been computed, at a rate of one output per cycle.

Top module: `lfw_wide_smooth`

## Requirements
- R1: While reset is asserted, and right after it is released, `in_ready` is 1 and `out_valid` is 0.
- R2: A column is accepted on a rising edge where `in_valid` and `in_ready` are both 1. From that edge, `in_ready` stays 0 for exactly 6 cycles in short mode and 14 cycles in long mode, then returns to 1.
- R3: `out_valid` is high for exactly one cycle. It rises after the 6th (short mode) or 14th (long mode) rising edge that follows the accepting edge, and `out_pix` is valid in that cycle.
- R4: Pixel k sits at bits [k*PIX_W +: PIX_W] of `in_pix` and `out_pix`. Index 0 is p7, 7 is p0, 8 is q0 and 15 is q7. `in_wide` = 1 selects long mode and `in_wide` = 0 selects short mode.
- R5: In short mode with `in_sel` = 1, output pixel i (i = 5..10) equals (pixel i + the sum of pixels clamp(j,4,11) for j = i-3..i+3, + 4) >> 3. For p2 this is (3·p3 + 2·p2 + p1 + p0 + q0 + 4) >> 3.
- R6: In long mode with `in_sel` = 1, output pixel i (i = 1..14) equals (pixel i + the sum of pixels clamp(j,0,15) for j = i-7..i+7, + 8) >> 4. For p6 this is (7·p7 + 2·p6 + p5 + p4 + p3 + p2 + p1 + p0 + q0 + 8) >> 4.
- R7: Each output after the first uses only unfiltered input pixels, even though earlier positions of the same column have already been rewritten. This is observable on ramps and steps.
- R8: With `in_sel` = 0, `out_pix` equals the accepted `in_pix` in both modes.
- R9: Pixels outside the rewrite band are returned unchanged: indices 0..4 and 11..15 in short mode, and indices 0 and 15 in long mode.
- R10: The accumulator never overflows. A column with every pixel at 2^PIX_W - 1 returns every pixel at 2^PIX_W - 1, and an all-zero column returns all zeros.
- R11: `in_ready` is 1 in the cycle in which `out_valid` is 1, so a held column is accepted back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Column on `in_pix` is offered |
| in_ready | output | 1 | Block can accept a column on this edge |
| in_wide | input | 1 | 1 = long mode (14 outputs), 0 = short mode (6 outputs) |
| in_sel | input | 1 | 1 = replace the band with smoothed values, 0 = pass through |
| in_pix | input | 16*PIX_W | Sixteen pixels, p7 at the lowest field |
| out_valid | output | 1 | One-cycle pulse: `out_pix` holds the finished column |
| out_pix | output | 16*PIX_W | Filtered column, same packing as `in_pix` |

## Verification
A wrong accumulator value spoils every later pixel of the column. Each step inherits the previous sum, so an error in the initial sum or in one tap pick shows up as a run of wrong pixels that starts at the first faulty position and reaches to q2 or q6. All of these surface in the single `out_valid` cycle, 6 or 14 cycles after acceptance. A wrong step counter or wrong mode shows up earlier, as `in_ready` returning in the wrong cycle, and again as `out_valid` missing the expected cycle. Because the reference rebuilds every window directly from the input column, it cannot share a drift with the incremental arithmetic. Ramps and steps are used so that a tap taken from an already rewritten pixel changes the result.

// File: rtl/lfw_pkg.sv
package lfw_pkg;
  // Number of pixels in one column across the edge (p7..p0, q0..q7).
  localparam int TAPS  = 16;
  localparam int IDX_W = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } lfw_state_e;

  // Tap bounds and rewrite band per mode (index 0 = p7, 15 = q7).
  localparam logic [IDX_W-1:0] LONG_LO    = 4'd0;
  localparam logic [IDX_W-1:0] LONG_HI    = 4'd15;
  localparam logic [IDX_W-1:0] SHORT_LO   = 4'd4;
  localparam logic [IDX_W-1:0] SHORT_HI   = 4'd11;
  localparam logic [IDX_W-1:0] LONG_FIRST = 4'd1;
  localparam logic [IDX_W-1:0] LONG_LAST  = 4'd14;
  localparam logic [IDX_W-1:0] SHORT_FIRST = 4'd5;
  localparam logic [IDX_W-1:0] SHORT_LAST  = 4'd10;
  // Half window reach on each side of the centre tap.
  localparam logic [2:0] LONG_REACH  = 3'd7;
  localparam logic [2:0] SHORT_REACH = 3'd3;
endpackage

// File: rtl/lfw_sum_init.sv
module lfw_sum_init
  import lfw_pkg::*;
#(
  parameter int PIX_W = 10,
  parameter int SUM_W = PIX_W + 5
) (
  input  logic [PIX_W-1:0] pix [TAPS],
  input  logic             wide,
  output logic [SUM_W-1:0] sum0
);

  logic [SUM_W-1:0] long_acc;
  logic [SUM_W-1:0] short_acc;

  // Long window start: 7*p7 + 2*p6 + p5..q0 + 8
  always_comb begin
    long_acc = (SUM_W'(pix[0]) << 3) - SUM_W'(pix[0]) + (SUM_W'(pix[1]) << 1);
    for (int k = 2; k <= 8; k++) begin
      long_acc = long_acc + SUM_W'(pix[k]);
    end
    long_acc = long_acc + SUM_W'(8);
  end

  // Short window start: 3*p3 + 2*p2 + p1 + p0 + q0 + 4
  always_comb begin
    short_acc = (SUM_W'(pix[4]) << 2) - SUM_W'(pix[4]) + (SUM_W'(pix[5]) << 1);
    for (int k = 6; k <= 8; k++) begin
      short_acc = short_acc + SUM_W'(pix[k]);
    end
    short_acc = short_acc + SUM_W'(4);
  end

  assign sum0 = wide ? long_acc : short_acc;

endmodule

// File: rtl/lfw_sum_step.sv
module lfw_sum_step
  import lfw_pkg::*;
#(
  parameter int PIX_W = 10,
  parameter int SUM_W = PIX_W + 5
) (
  input  logic [PIX_W-1:0] pix [TAPS],
  input  logic [SUM_W-1:0] sum,
  input  logic [IDX_W-1:0] idx,
  input  logic             wide,
  output logic [SUM_W-1:0] sum_nxt,
  output logic [PIX_W-1:0] filt
);

  logic [2:0]       reach;
  logic [IDX_W-1:0] lo;
  logic [IDX_W-1:0] hi;
  logic [IDX_W-1:0] left_tap;
  logic [IDX_W-1:0] right_tap;
  logic [IDX_W-1:0] next_tap;
  logic [IDX_W:0]   right_raw;

  always_comb begin
    reach = wide ? LONG_REACH : SHORT_REACH;
    lo    = wide ? LONG_LO    : SHORT_LO;
    hi    = wide ? LONG_HI    : SHORT_HI;

    // Tap leaving on the left, clamped to the outermost pixel.
    if (idx >= lo + IDX_W'(reach)) begin
      left_tap = idx - IDX_W'(reach);
    end else begin
      left_tap = lo;
    end

    // Tap entering on the right, clamped to the outermost pixel.
    right_raw = {1'b0, idx} + (IDX_W+1)'(reach) + (IDX_W+1)'(1);
    if (right_raw > {1'b0, hi}) begin
      right_tap = hi;
    end else begin
      right_tap = right_raw[IDX_W-1:0];
    end

    next_tap = idx + IDX_W'(1);

    // All four taps come from the unfiltered column.
    sum_nxt = sum
            - SUM_W'(pix[idx])
            - SUM_W'(pix[left_tap])
            + SUM_W'(pix[next_tap])
            + SUM_W'(pix[right_tap]);

    filt = wide ? sum[PIX_W+3:4] : sum[PIX_W+2:3];
  end

endmodule

// File: rtl/lfw_ctrl.sv
module lfw_ctrl
  import lfw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_wide,
  input  logic             run_wide,
  output logic             busy,
  output logic             step_en,
  output logic             last_step,
  output logic [IDX_W-1:0] idx,
  output logic             done
);

  lfw_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] last_idx;

  assign last_idx  = run_wide ? LONG_LAST : SHORT_LAST;
  assign step_en   = (state_q == ST_RUN);
  assign last_step = step_en && (idx_q == last_idx);
  assign busy      = step_en;
  assign idx       = idx_q;
  assign done      = done_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = step_en && last_step;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          idx_d   = start_wide ? LONG_FIRST : SHORT_FIRST;
        end
      end
      ST_RUN: begin
        idx_d = idx_q + IDX_W'(1);
        if (last_step) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

endmodule

// File: rtl/lfw_wide_smooth.sv
module lfw_wide_smooth
  import lfw_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_wide,
  input  logic                  in_sel,
  input  logic [TAPS*PIX_W-1:0] in_pix,
  output logic                  out_valid,
  output logic [TAPS*PIX_W-1:0] out_pix
);

  // 16 * (2^PIX_W - 1) + 8 fits in PIX_W + 4 bits; one spare bit kept.
  localparam int SUM_W = PIX_W + 5;

  logic [PIX_W-1:0] in_arr [TAPS];
  logic [PIX_W-1:0] orig_q [TAPS];
  logic [PIX_W-1:0] orig_d [TAPS];
  logic [PIX_W-1:0] res_q  [TAPS];
  logic [PIX_W-1:0] res_d  [TAPS];
  logic [SUM_W-1:0] sum_q, sum_d, sum0, sum_nxt;
  logic             wide_q, wide_d;
  logic             sel_q, sel_d;
  logic [PIX_W-1:0] filt;
  logic             busy, step_en, last_step, accept, load_en;
  logic [IDX_W-1:0] idx;

  genvar g;
  generate
    for (g = 0; g < TAPS; g++) begin : g_pack
      assign in_arr[g]                 = in_pix[g*PIX_W +: PIX_W];
      assign out_pix[g*PIX_W +: PIX_W] = res_q[g];
    end
  endgenerate

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign load_en  = accept || step_en;

  lfw_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_wide (in_wide),
    .run_wide   (wide_q),
    .busy       (busy),
    .step_en    (step_en),
    .last_step  (last_step),
    .idx        (idx),
    .done       (out_valid)
  );

  lfw_sum_init #(.PIX_W(PIX_W), .SUM_W(SUM_W)) u_init (
    .pix  (in_arr),
    .wide (in_wide),
    .sum0 (sum0)
  );

  lfw_sum_step #(.PIX_W(PIX_W), .SUM_W(SUM_W)) u_step (
    .pix     (orig_q),
    .sum     (sum_q),
    .idx     (idx),
    .wide    (wide_q),
    .sum_nxt (sum_nxt),
    .filt    (filt)
  );

  always_comb begin
    orig_d = orig_q;
    res_d  = res_q;
    sum_d  = sum_q;
    wide_d = wide_q;
    sel_d  = sel_q;
    if (accept) begin
      orig_d = in_arr;
      res_d  = in_arr;
      sum_d  = sum0;
      wide_d = in_wide;
      sel_d  = in_sel;
    end else if (step_en) begin
      res_d[idx] = sel_q ? filt : orig_q[idx];
      sum_d      = sum_nxt;
    end
  end

  // Datapath registers: clock-enabled, no reset needed.
  always_ff @(posedge clk) begin
    if (load_en) begin
      orig_q <= orig_d;
      res_q  <= res_d;
      sum_q  <= sum_d;
      wide_q <= wide_d;
      sel_q  <= sel_d;
    end
  end

endmodule

// File: rtl/lfw_wide_smooth_chk.sv
module lfw_wide_smooth_chk
  import lfw_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  in_wide,
  input logic [TAPS*PIX_W-1:0] in_pix,
  input logic                  out_valid,
  input logic [TAPS*PIX_W-1:0] out_pix
);

  localparam int OFF_P7 = 0;
  localparam int OFF_P3 = 4 * PIX_W;
  localparam int OFF_Q3 = 11 * PIX_W;
  localparam int OFF_Q7 = 15 * PIX_W;

  logic                  acc;
  logic                  pend_q;
  logic                  cap_wide_q;
  logic [TAPS*PIX_W-1:0] cap_pix_q;
  logic [4:0]            cnt_q;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      cap_wide_q <= 1'b0;
      cap_pix_q  <= '0;
      cnt_q      <= '0;
    end else if (acc) begin
      pend_q     <= 1'b1;
      cap_wide_q <= in_wide;
      cap_pix_q  <= in_pix;
      cnt_q      <= '0;
    end else if (out_valid) begin
      pend_q <= 1'b0;
    end else if (pend_q) begin
      cnt_q <= cnt_q + 5'd1;
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !in_ready); // R2

  AST_READY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |-> in_ready); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R3

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pend_q && cnt_q == (cap_wide_q ? 5'd14 : 5'd6))); // R3

  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready); // R11

  AST_OUTER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_pix[OFF_P7 +: PIX_W] == cap_pix_q[OFF_P7 +: PIX_W] &&
                   out_pix[OFF_Q7 +: PIX_W] == cap_pix_q[OFF_Q7 +: PIX_W])); // R9

  AST_SHORT_BOUND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cap_wide_q) |->
      (out_pix[OFF_P3 +: PIX_W] == cap_pix_q[OFF_P3 +: PIX_W] &&
       out_pix[OFF_Q3 +: PIX_W] == cap_pix_q[OFF_Q3 +: PIX_W])); // R9

endmodule

bind lfw_wide_smooth lfw_wide_smooth_chk #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_wide   (in_wide),
  .in_pix    (in_pix),
  .out_valid (out_valid),
  .out_pix   (out_pix)
);

// File: tb/lfw_wide_smooth_bench.sv
`timescale 1ns/1ps
module lfw_wide_smooth_bench;
  localparam int W    = 10;
  localparam int N    = 16;
  localparam int MAXV = (1 << W) - 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic           in_wide = 1'b0;
  logic           in_sel = 1'b0;
  logic [N*W-1:0] in_pix = '0;
  logic           out_valid;
  logic [N*W-1:0] out_pix;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int ready_at = 0;
  bit monitor_on = 1'b0;
  bit finished = 1'b0;

  logic [N*W-1:0] exp_q[$];
  int             due_q[$];
  bit             wide_q[$];
  string          tag_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lfw_wide_smooth #(.PIX_W(W)) u_lfw_wide_smooth (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_wide(in_wide), .in_sel(in_sel), .in_pix(in_pix),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d (edge %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  // Direct window reference: each output rebuilt from the input column.
  function automatic logic [N*W-1:0] model(input bit wide, input bit sel, input int px[N]);
    logic [N*W-1:0] r;
    int lo, hi, reach, sh, rnd, first, last;
    lo = wide ? 0 : 4;  hi = wide ? 15 : 11;
    reach = wide ? 7 : 3; sh = wide ? 4 : 3; rnd = wide ? 8 : 4;
    first = lo + 1; last = hi - 1;
    for (int k = 0; k < N; k++) begin
      int v;
      v = px[k];
      if (sel && k >= first && k <= last) begin
        int acc;
        acc = px[k] + rnd;
        for (int j = k - reach; j <= k + reach; j++) acc += px[clampi(j, lo, hi)];
        v = acc >> sh;
      end
      r[k*W +: W] = W'(v);
    end
    return r;
  endfunction

  task automatic send(input bit wide, input bit sel, input int px[N], input string tag);
    logic [N*W-1:0] p;
    for (int k = 0; k < N; k++) p[k*W +: W] = W'(px[k] & MAXV);
    #1;
    in_pix = p; in_wide = wide; in_sel = sel; in_valid = 1'b1;
    while (!in_ready) @(negedge clk) #1;
    begin
      int pm[N];
      for (int k = 0; k < N; k++) pm[k] = px[k] & MAXV;
      exp_q.push_back(model(wide, sel, pm));
    end
    due_q.push_back(cyc + 1 + (wide ? 14 : 6));
    ready_at = cyc + 1 + (wide ? 14 : 6);
    wide_q.push_back(wide);
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Per-cycle comparison against the reference timing and data.
  always @(negedge clk) begin
    if (monitor_on) begin
      bit ev, er;
      ev = (due_q.size() > 0) && (due_q[0] == cyc);
      er = (cyc >= ready_at);
      chk("R3", "out_valid", int'(out_valid), int'(ev));
      chk(ev ? "R11" : "R2", "in_ready", int'(in_ready), int'(er));
      if (ev) begin
        logic [N*W-1:0] e;
        bit wd;
        string tg;
        e = exp_q.pop_front(); wd = wide_q.pop_front(); tg = tag_q.pop_front();
        void'(due_q.pop_front());
        if (out_valid) begin
          for (int k = 0; k < N; k++) begin
            bit outside;
            outside = wd ? (k == 0 || k == 15) : (k <= 4 || k >= 11);
            chk(outside ? "R9" : tg, $sformatf("pixel %0d", k),
                int'(out_pix[k*W +: W]), int'(e[k*W +: W]));
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int px[N];
    repeat (3) @(negedge clk);
    chk("R1", "in_ready in reset", int'(in_ready), 1);
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "in_ready after reset", int'(in_ready), 1);
    chk("R1", "out_valid after reset", int'(out_valid), 0);
    monitor_on = 1'b1;

    for (int k = 0; k < N; k++) px[k] = 100;
    send(1'b0, 1'b1, px, "R5");
    idle(3);
    for (int k = 0; k < N; k++) px[k] = 300;
    send(1'b1, 1'b1, px, "R6");
    for (int k = 0; k < N; k++) px[k] = (k < 8) ? 200 : 260;
    send(1'b0, 1'b1, px, "R5");
    for (int k = 0; k < N; k++) px[k] = (k < 8) ? 100 : 180;
    send(1'b1, 1'b1, px, "R6");
    for (int k = 0; k < N; k++) px[k] = k * 37;
    send(1'b1, 1'b1, px, "R7");
    for (int k = 0; k < N; k++) px[k] = 900 - k * 53;
    send(1'b0, 1'b1, px, "R7");
    for (int k = 0; k < N; k++) px[k] = (k * 61 + 13) % 1024;
    send(1'b1, 1'b1, px, "R4");
    send(1'b0, 1'b1, px, "R4");
    for (int k = 0; k < N; k++) px[k] = k * 37;
    send(1'b1, 1'b0, px, "R8");
    send(1'b0, 1'b0, px, "R8");
    for (int k = 0; k < N; k++) px[k] = MAXV;
    send(1'b1, 1'b1, px, "R10");
    send(1'b0, 1'b1, px, "R10");
    for (int k = 0; k < N; k++) px[k] = 0;
    send(1'b1, 1'b1, px, "R10");
    idle(2);
    for (int t = 0; t < 12; t++) begin
      for (int k = 0; k < N; k++) px[k] = int'($urandom_range(0, MAXV));
      send(t[0], 1'b1, px, t[0] ? "R6" : "R5");
      if (t % 4 == 3) idle(t);
    end
    while (due_q.size() > 0) @(negedge clk);
    idle(3);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule